// File: doc/BRIEF.md
# MDIO Management Master

The block is a register-driven master for the two-wire management bus found between a MAC and its PHYs. Software writes one 32-bit command word holding a launch bit, a frame-kind bit, an operation code, a port address, a register (or device) address and a 16-bit payload. The block then clocks out one complete management frame on MDC/MDIO. For read frames it releases the data line at turnaround and collects the 16 bits returned by the PHY.

A second register reports the captured read value and an idle flag, and holds the threshold that sets the MDC rate. Completion shows up in two places: the launch bit clears itself, and the idle flag returns to 1. Extended (Clause 45) accesses take two launches, an address frame and then a data frame. Software issues both of them.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register (offset 0x0) reads 0x00000000, and the status register (offset 0x4) reads 0x04010000: threshold 4 in bits 31:24, idle bit 16 set, read value 0.
- R2: A write to offset 0x0 with bit 31 set, made while idle, starts a frame. Bit 31 of offset 0x0 reads 1 and status bit 16 reads 0 from the next cycle until the frame ends. Then they read 0 and 1.
- R3: Each frame is 64 bits, sent MSB first. It carries 32 ones, then start code 01 when command bit 28 is 1 or 00 when it is 0, then opcode bits 27:26, port bits 25:21, and register/device bits 20:16.
- R4: In a frame that is not a read, the master drives turnaround 1,0 and then command bits 15:0, and it keeps the output enable high for all 64 bits.
- R5: A frame is a read when bit 28 is 1 with opcode 10, or when bit 28 is 0 with opcode 10 or 11. In a read, the output enable is low for the last 18 bits, and the 16 bits sampled on rising MDC edges end up in status bits 15:0.
- R6: Status bits 15:0 change only when a read frame completes. A frame that is not a read leaves them unchanged.
- R7: A write to offset 0x0 while a frame is in progress is ignored. The frame on the wire and the stored command fields stay those of the running frame.
- R8: Status bits 31:24 are writable. Each half period of MDC lasts max(threshold,1) system clocks, and MDC stays low while idle.
- R9: MDIO output and output enable change only at a falling MDC edge or at launch, never while MDC is high.
- R10: A write to offset 0x0 with bit 31 clear stores the fields but starts no frame: MDC does not toggle and the idle flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Sampled level of the MDIO line |
| mdio_out | output | 1 | Value driven on MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The hardest case to reach is a second command write that lands in the middle of a running frame. The stimulus waits about forty clocks after a launch and then writes a command with different fields and the launch bit set. It checks that exactly 64 MDC rises occur, that the captured frame matches the first command, and that the stored fields still read back as the first command. A bench-side PHY model shifts a response word onto MDIO after each falling edge of the data phase. This tests the ordering of read bits and the release of the line. Two thresholds, 0 and 3, exercise the clamp and the divider period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_LEN = 64;
    localparam int PRE_LEN   = 32;
    localparam int TA_IDX    = 46;
    localparam int DAT_IDX   = 48;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int GO_BIT    = 31;

    typedef struct packed {
        logic        c22;
        logic [1:0]  op;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] payload;
    } mdio_cmd_t;

    function automatic mdio_cmd_t unpack_cmd(logic [31:0] w);
        mdio_cmd_t c;
        c.c22     = w[28];
        c.op      = w[27:26];
        c.port    = w[25:21];
        c.dev     = w[20:16];
        c.payload = w[15:0];
        return c;
    endfunction

    function automatic logic is_read_frame(mdio_cmd_t c);
        return c.c22 ? (c.op == 2'b10) : c.op[1];
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(mdio_cmd_t c);
        return {{PRE_LEN{1'b1}}, 1'b0, c.c22, c.op, c.port, c.dev, 2'b10, c.payload};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [THR_W-1:0] thr,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [THR_W-1:0] cnt;
    logic [THR_W-1:0] lim;
    logic             tick;

    always_comb begin
        lim      = (thr == '0) ? THR_W'(1) : thr;
        tick     = run && (cnt >= lim - THR_W'(1));
        rise_stb = tick && !mdc;
        fall_stb = tick && mdc;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + THR_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        launch,
    input  mdio_cmd_t   cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_in,
    output logic        busy,
    output logic        done,
    output logic        rd_kind,
    output logic [15:0] rx_word,
    output logic        mdio_out,
    output logic        mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] shreg;
    logic [IDX_W-1:0]     cur;

    always_comb begin
        done     = busy && fall_stb && (cur == LAST_IDX);
        mdio_out = busy ? shreg[FRAME_LEN-1] : 1'b1;
        mdio_oe  = busy && !(rd_kind && (cur >= IDX_W'(TA_IDX)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cur     <= '0;
            shreg   <= '0;
            rd_kind <= 1'b0;
            rx_word <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy    <= 1'b1;
                cur     <= '0;
                shreg   <= build_frame(cmd);
                rd_kind <= is_read_frame(cmd);
            end
        end else begin
            if (rise_stb && rd_kind && (cur >= IDX_W'(DAT_IDX)))
                rx_word <= {rx_word[14:0], mdio_in};
            if (fall_stb) begin
                if (cur == LAST_IDX) begin
                    busy <= 1'b0;
                end else begin
                    cur   <= cur + IDX_W'(1);
                    shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int              ADDR_W  = 4,
    parameter int              THR_W   = 8,
    parameter logic [THR_W-1:0] THR_RST = 8'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam logic [ADDR_W-1:0] CMD_OFF  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(4);
    localparam int                PAD_W    = 32 - THR_W - 17;

    mdio_cmd_t        cmd_q;
    logic [THR_W-1:0] thr_q;
    logic [15:0]      rd_data_q;
    logic             busy, done, rd_kind, launch, cmd_wr;
    logic             rise_stb, fall_stb;
    logic [15:0]      rx_word;

    assign cmd_wr = reg_we && (reg_addr == CMD_OFF) && !busy;
    assign launch = cmd_wr && reg_wdata[GO_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            thr_q     <= THR_RST;
            rd_data_q <= '0;
        end else begin
            if (cmd_wr)
                cmd_q <= unpack_cmd(reg_wdata);
            if (reg_we && (reg_addr == STAT_OFF))
                thr_q <= reg_wdata[31 -: THR_W];
            if (done && rd_kind)
                rd_data_q <= rx_word;
        end
    end

    always_comb begin
        case (reg_addr)
            CMD_OFF:  reg_rdata = {busy, 2'b00, cmd_q};
            STAT_OFF: reg_rdata = {thr_q, {PAD_W{1'b0}}, !busy, rd_data_q};
            default:  reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.THR_W(THR_W)) i_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .thr      (thr_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame i_frame (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .cmd      (unpack_cmd(reg_wdata)),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_in  (mdio_in),
        .busy     (busy),
        .done     (done),
        .rd_kind  (rd_kind),
        .rx_word  (rx_word),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input mdio_cmd_t   cmd_q,
    input logic [15:0] rd_data
);
    p_pins_hold_high_mdc_r9: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    p_mdc_parked_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_cmd_frozen_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q));

    p_rdata_at_end_only_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_data) |-> ($past(busy) && !busy));
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .cmd_q    (cmd_q),
    .rd_data  (rd_data_q)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // entry: {c22, op, port, dev, payload, phy response}
    localparam int NV = 7;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 2'b01, 5'd1,  5'd0,  16'h1140, 16'h0000},
        {1'b1, 2'b10, 5'd3,  5'd2,  16'h0000, 16'h0141},
        {1'b0, 2'b00, 5'd5,  5'd1,  16'h0007, 16'h0000},
        {1'b0, 2'b11, 5'd5,  5'd1,  16'h0000, 16'hBEEF},
        {1'b0, 2'b01, 5'd31, 5'd30, 16'hA5A5, 16'h1234},
        {1'b0, 2'b10, 5'd0,  5'd31, 16'h0000, 16'h8001},
        {1'b1, 2'b11, 5'd9,  5'd4,  16'h5A5A, 16'hFFFF}
    };

    mdio_master i_mdio_master (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    always #4 clk = ~clk;

    // PHY model and bus monitor
    int          rise_cnt = 0;
    int          late_hi  = 0;
    int          early_lo = 0;
    int          base     = 0;
    logic [15:0] resp_q   = '0;
    logic [63:0] cap      = '0;
    time         t_last   = 0;
    time         t_prev   = 0;
    int          hold_viol = 0;
    logic        prev_mdc = 1'b0, prev_out = 1'b1, prev_oe = 1'b0;

    always @(posedge mdc) begin
        if (rise_cnt - base >= 46 && mdio_oe) late_hi <= late_hi + 1;
        if (rise_cnt - base < 46 && !mdio_oe) early_lo <= early_lo + 1;
        cap      <= {cap[62:0], mdio_out};
        rise_cnt <= rise_cnt + 1;
        t_prev   <= t_last;
        t_last   <= $time;
    end

    always @(negedge mdc) begin
        if (rise_cnt - base >= 48 && rise_cnt - base < 64)
            mdio_in <= resp_q[63 - (rise_cnt - base)];
        else
            mdio_in <= 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && mdc && prev_mdc && (mdio_out != prev_out || mdio_oe != prev_oe))
            hold_viol <= hold_viol + 1;
        prev_mdc <= mdc;
        prev_out <= mdio_out;
        prev_oe  <= mdio_oe;
        if (cyc > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            rd(4'h0, v);
            if (!v[31]) break;
        end
    endtask

    function automatic logic [31:0] cmd_word(logic go, logic c22, logic [1:0] op,
                                             logic [4:0] p, logic [4:0] d,
                                             logic [15:0] pl);
        return {go, 2'b00, c22, op, p, d, pl};
    endfunction

    function automatic logic [63:0] exp_frame(logic c22, logic [1:0] op, logic [4:0] p,
                                              logic [4:0] d, logic [15:0] pl);
        return {32'hFFFF_FFFF, 1'b0, c22, op, p, d, 2'b10, pl};
    endfunction

    int snap_late, snap_early, snap_rise;

    task automatic run_frame(input logic c22, input logic [1:0] op, input logic [4:0] p,
                             input logic [4:0] d, input logic [15:0] pl,
                             input logic [15:0] resp);
        logic [31:0] v;
        resp_q     = resp;
        base       = rise_cnt;
        snap_late  = late_hi;
        snap_early = early_lo;
        snap_rise  = rise_cnt;
        wr(4'h0, cmd_word(1'b1, c22, op, p, d, pl));
        rd(4'h0, v);
        check(v[31] == 1'b1, "R2 busy after launch", 64'(v[31]), 64'd1);
        rd(4'h4, v);
        check(v[16] == 1'b0, "R2 idle low during frame", 64'(v[16]), 64'd0);
        wait_idle();
        repeat (2) @(negedge clk);
    endtask

    logic [15:0] exp_rd;

    initial begin
        logic [31:0] v;
        logic        rdk;
        logic [63:0] ef;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v);
        check(v == 32'h0, "R1 command reg after reset", 64'(v), 64'h0);
        rd(4'h4, v);
        check(v == 32'h0401_0000, "R1 status reg after reset", 64'(v), 64'h0401_0000);

        exp_rd = 16'h0;
        for (int i = 0; i < NV; i++) begin
            logic c22; logic [1:0] op; logic [4:0] p, d; logic [15:0] pl, rs;
            {c22, op, p, d, pl, rs} = VEC[i];
            rdk = c22 ? (op == 2'b10) : op[1];
            run_frame(c22, op, p, d, pl, rs);
            ef = exp_frame(c22, op, p, d, pl);
            rd(4'h0, v);
            check(v[31] == 1'b0, "R2 start bit clears", 64'(v[31]), 64'd0);
            rd(4'h4, v);
            check(v[16] == 1'b1, "R2 idle set after frame", 64'(v[16]), 64'd1);
            check(rise_cnt - snap_rise == 64, "R3 frame length",
                  64'(rise_cnt - snap_rise), 64'd64);
            check(cap[63:18] == ef[63:18], "R3 frame header", cap, ef);
            check(early_lo == snap_early, "R4 enable during header",
                  64'(early_lo - snap_early), 64'd0);
            if (rdk) begin
                exp_rd = rs;
                check(late_hi == snap_late, "R5 line released for read",
                      64'(late_hi - snap_late), 64'd0);
            end else begin
                check(cap == ef, "R4 turnaround and payload", cap, ef);
                check(late_hi - snap_late == 18, "R4 enable through payload",
                      64'(late_hi - snap_late), 64'd18);
            end
            check(v[15:0] == exp_rd, rdk ? "R5 read data captured" : "R6 read data kept",
                  64'(v[15:0]), 64'(exp_rd));
        end

        // R7: write during a frame is ignored
        resp_q    = 16'h0;
        base      = rise_cnt;
        snap_rise = rise_cnt;
        wr(4'h0, cmd_word(1'b1, 1'b1, 2'b01, 5'd7, 5'd3, 16'hC3C3));
        repeat (40) @(negedge clk);
        wr(4'h0, cmd_word(1'b1, 1'b0, 2'b11, 5'd20, 5'd12, 16'h0F0F));
        wait_idle();
        repeat (10) @(negedge clk);
        check(rise_cnt - snap_rise == 64, "R7 single frame only",
              64'(rise_cnt - snap_rise), 64'd64);
        ef = exp_frame(1'b1, 2'b01, 5'd7, 5'd3, 16'hC3C3);
        check(cap == ef, "R7 frame of first command", cap, ef);
        rd(4'h0, v);
        check(v == cmd_word(1'b0, 1'b1, 2'b01, 5'd7, 5'd3, 16'hC3C3),
              "R7 stored fields kept", 64'(v),
              64'(cmd_word(1'b0, 1'b1, 2'b01, 5'd7, 5'd3, 16'hC3C3)));

        // R10: no launch without start bit
        snap_rise = rise_cnt;
        wr(4'h0, cmd_word(1'b0, 1'b1, 2'b10, 5'd2, 5'd1, 16'h0));
        repeat (30) @(negedge clk);
        check(rise_cnt == snap_rise, "R10 no MDC activity", 64'(rise_cnt - snap_rise), 64'd0);
        rd(4'h4, v);
        check(v[16] == 1'b1, "R10 idle stays set", 64'(v[16]), 64'd1);
        rd(4'h0, v);
        check(v == cmd_word(1'b0, 1'b1, 2'b10, 5'd2, 5'd1, 16'h0), "R10 fields stored",
              64'(v), 64'(cmd_word(1'b0, 1'b1, 2'b10, 5'd2, 5'd1, 16'h0)));

        // R8: threshold clamp and divider
        wr(4'h4, 32'h0000_FFFF);
        rd(4'h4, v);
        check(v[31:24] == 8'd0, "R8 threshold written", 64'(v[31:24]), 64'd0);
        check(v[15:0] == exp_rd, "R6 status write keeps data", 64'(v[15:0]), 64'(exp_rd));
        run_frame(1'b1, 2'b01, 5'd1, 5'd1, 16'h1234, 16'h0);
        check(t_last - t_prev == 16, "R8 period with threshold 0",
              64'(t_last - t_prev), 64'd16);
        wr(4'h4, 32'h0300_0000);
        run_frame(1'b1, 2'b01, 5'd1, 5'd1, 16'h4321, 16'h0);
        check(t_last - t_prev == 48, "R8 period with threshold 3",
              64'(t_last - t_prev), 64'd48);
        check(mdc == 1'b0, "R8 MDC low when idle", 64'(mdc), 64'd0);

        check(hold_viol == 0, "R9 pins stable while MDC high", 64'(hold_viol), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule